// File: doc/BRIEF.md
# Translation Cache with Masked Invalidation

This block keeps recently completed address translations so that a page walker does not have to repeat them. It holds two small fully associative arrays. The page array stores, for each 4 KB virtual page, the physical frame and a 4-bit authority index. The walk array stores, for each 1 MB region, the address of the second-level table that covers it. Lookups on either array are combinational and answer in the same cycle. Entries arrive from the walker through fill ports.

Software maintains the arrays through a small register window. It can remove page entries whose tag agrees with a target address under a mask it writes. It can remove the walk entry for one 1 MB region. It can also empty either array entirely, or send a one-cycle flush strobe to each of six per-requester micro-TLBs. Every maintenance request is a bit that reads back 1 until its work is finished, so software polls the same bit for completion.

A single sequencer carries out the queued operations one at a time. It visits one entry per clock. Fills are refused while any maintenance work is outstanding. A lookup that targets the entry being removed in that very cycle already reports a miss.

Top module: `xlat_cache`

## Requirements
- R1: After reset both arrays hold no valid entry, every register reads 0, no busy bit is set and `utlb_flush` is 0.
- R2: `lk_hit` is 1 in the same cycle when `lk_va[31:12]` equals the tag of a valid page entry, with `lk_frame`/`lk_aci` from that entry; the low 12 address bits are ignored; otherwise `lk_hit` is 0. `wl_hit`/`wl_table` behave alike on `wl_va[31:20]`.
- R3: A fill whose tag is not cached is written to the slot of a round-robin pointer that starts at slot 0 after reset and advances by one per such fill, wrapping after the last slot. A fill whose tag is already cached overwrites that entry in place and leaves the pointer unchanged, so a tag never hits in two slots.
- R4: Register select 0 holds the invalidate address and select 1 the invalidate mask. Writing 1 to bit 0 of select 2 removes every page entry whose tag agrees with address bits 31:12 in every position where mask bits 31:12 are 1. Mask 0xFFFFF000 removes one page, and mask 0 removes all pages.
- R5: The select-2 busy bit reads 1 from the cycle after the start write until the operation ends. With nothing queued ahead of it, that is exactly 8 cycles (one per page slot). After that it reads 0.
- R6: Select 3 holds a walk address. Writing 1 to bit 0 of select 4 removes the walk entry whose tag equals address bits 31:20. Its busy bit reads 1 for exactly 4 cycles when nothing is queued ahead.
- R7: In select 5, writing bit 17 empties the walk array and writing bit 16 empties the page array. Each bit reads 1 until its own flush is done, and neither flush touches the other array.
- R8: Bits 5:0 written to select 5 appear on `utlb_flush` and in select-5 bits 5:0 for exactly the one cycle after the write, and then read 0.
- R9: A fill on either port is discarded at any clock edge where a maintenance operation is queued or running, or a micro-TLB strobe is set.
- R10: A lookup of the entry that the sequencer removes in the current cycle reports a miss in that cycle.
- R11: Writes to the invalidate address or mask registers are ignored while the select-2 operation is busy. Writes to the walk address are ignored while the select-4 operation is busy.
- R12: Queued operations run one at a time in the order walk flush, page flush, page invalidate, walk invalidate. Each busy bit stays 1 until its own operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_va | input | 32 | Page lookup virtual address |
| lk_hit | output | 1 | Page lookup hit |
| lk_frame | output | 20 | Physical frame of the hit entry |
| lk_aci | output | 4 | Authority index of the hit entry |
| fl_valid | input | 1 | Page fill strobe |
| fl_va | input | 32 | Virtual address of the page fill |
| fl_frame | input | 20 | Frame of the page fill |
| fl_aci | input | 4 | Authority index of the page fill |
| wl_va | input | 32 | Walk lookup virtual address |
| wl_hit | output | 1 | Walk lookup hit |
| wl_table | output | 22 | Table address of the hit walk entry |
| wf_valid | input | 1 | Walk fill strobe |
| wf_va | input | 32 | Virtual address of the walk fill |
| wf_table | input | 22 | Table address of the walk fill |
| utlb_flush | output | 6 | One-cycle per-requester micro-TLB flush strobes |

## Verification
The hardest situation to reach is a lookup that lands on the slot the sequencer is removing in that same cycle. From the ports, the bench only controls which slot is scanned first by knowing where each entry was placed. So it resets the block to put the round-robin pointer at slot 0, fills all eight slots with known tags, and starts a mask-zero invalidate. In the first cycle after the start write it looks up both the slot-0 tag, which must miss, and the slot-1 tag, which must still hit. Queue ordering is reached by setting both flush bits in one write and then sampling both busy bits every cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   localparam int REG_W       = 32;
   localparam int PG_SHIFT    = 12;
   localparam int DIR_SHIFT   = 20;
   localparam int FL_WALK_BIT = 17;
   localparam int FL_PAGE_BIT = 16;
   localparam int N_OPS       = 4;

   // register window selects
   typedef enum logic [2:0] {
      SEL_IADDR = 3'd0,
      SEL_IMASK = 3'd1,
      SEL_IGO   = 3'd2,
      SEL_WADDR = 3'd3,
      SEL_WGO   = 3'd4,
      SEL_FLUSH = 3'd5
   } sel_e;

   // queued operation, value is also service priority (lowest first)
   typedef enum logic [1:0] {
      OP_FLW  = 2'd0,
      OP_FLP  = 2'd1,
      OP_INVP = 2'd2,
      OP_INVW = 2'd3
   } op_e;
endpackage

// File: rtl/xlat_assoc.sv
module xlat_assoc #(
   parameter int TAG_W = 20,
   parameter int DAT_W = 24,
   parameter int DEPTH = 8,
   parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [DAT_W-1:0] lk_dat,
   input  logic             fl_en,
   input  logic [TAG_W-1:0] fl_tag,
   input  logic [DAT_W-1:0] fl_dat,
   input  logic             sc_en,
   input  logic             sc_all,
   input  logic [IDX_W-1:0] sc_idx,
   input  logic [TAG_W-1:0] sc_tag,
   input  logic [TAG_W-1:0] sc_mask,
   output logic [DEPTH-1:0] vld_o,
   output logic [DEPTH-1:0] hit_o
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("xlat_assoc: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] hit_raw;
   logic [DEPTH-1:0] kill;
   logic [DEPTH-1:0] fhit;
   logic [TAG_W-1:0] tag_a [DEPTH];
   logic [DAT_W-1:0] dat_a [DEPTH];
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] wr_idx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [DAT_W-1:0] d_q;

      assign vld_o[g]   = v_q;
      assign tag_a[g]   = t_q;
      assign dat_a[g]   = d_q;
      assign hit_raw[g] = v_q && (t_q == lk_tag);
      assign fhit[g]    = v_q && (t_q == fl_tag);
      assign kill[g]    = sc_en && (sc_idx == IDX_W'(g)) &&
                          (sc_all || (((t_q ^ sc_tag) & sc_mask) == '0));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (kill[g]) begin
            v_q <= 1'b0;
         end else if (fl_en && (wr_idx == IDX_W'(g))) begin
            v_q <= 1'b1;
            t_q <= fl_tag;
            d_q <= fl_dat;
         end
      end
   end

   assign hit_o  = hit_raw & ~kill;
   assign lk_hit = |hit_o;

   always_comb begin
      lk_dat = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_o[i]) lk_dat = lk_dat | dat_a[i];
      end
   end

   // refill in place when the tag is present, otherwise round robin
   always_comb begin
      wr_idx = rr_q;
      for (int i = 0; i < DEPTH; i++) begin
         if (fhit[i]) wr_idx = IDX_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (fl_en && !(|fhit)) begin
         rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   logic unused_tags;
   assign unused_tags = ^{tag_a[0], tag_a[DEPTH-1]};
endmodule

// File: rtl/xlat_maint.sv
module xlat_maint
   import xlat_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int MAIN_N = 8,
   parameter int WALK_N = 4,
   parameter int N_UTLB = 6,
   parameter int CNT_W  = $clog2((MAIN_N > WALK_N) ? MAIN_N : WALK_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [VA_W-1:0]   inv_addr,
   output logic [VA_W-1:0]   inv_mask,
   output logic [VA_W-1:0]   walk_addr,
   output logic              sc_page,
   output logic              sc_walk,
   output logic              sc_all,
   output logic [CNT_W-1:0]  sc_idx,
   output logic [N_OPS-1:0]  pend_o,
   output logic [N_UTLB-1:0] utlb_o,
   output logic              busy_o
);
   logic [N_OPS-1:0]  pend_q, set_v, clr_v;
   logic [N_UTLB-1:0] utlb_q;
   logic [VA_W-1:0]   iaddr_q, imask_q, waddr_q;
   logic              act_q;
   op_e               cur_q, sel_op;
   logic [CNT_W-1:0]  idx_q, idx_now, last;
   logic              go, done, tgt_page, wr_fl;

   always_comb begin
      if (act_q)          sel_op = cur_q;
      else if (pend_q[0]) sel_op = OP_FLW;
      else if (pend_q[1]) sel_op = OP_FLP;
      else if (pend_q[2]) sel_op = OP_INVP;
      else                sel_op = OP_INVW;
      go       = act_q || (|pend_q);
      idx_now  = act_q ? idx_q : '0;
      tgt_page = (sel_op == OP_FLP) || (sel_op == OP_INVP);
      last     = tgt_page ? CNT_W'(MAIN_N - 1) : CNT_W'(WALK_N - 1);
      done     = go && (idx_now == last);
   end

   assign wr_fl = cfg_we && (cfg_sel == SEL_FLUSH);

   always_comb begin
      set_v          = '0;
      set_v[OP_FLW]  = wr_fl && cfg_wdata[FL_WALK_BIT];
      set_v[OP_FLP]  = wr_fl && cfg_wdata[FL_PAGE_BIT];
      set_v[OP_INVP] = cfg_we && (cfg_sel == SEL_IGO) && cfg_wdata[0];
      set_v[OP_INVW] = cfg_we && (cfg_sel == SEL_WGO) && cfg_wdata[0];
      clr_v          = '0;
      if (done) clr_v[sel_op] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         utlb_q <= '0;
         act_q  <= 1'b0;
         cur_q  <= OP_FLW;
         idx_q  <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_v) | set_v;
         utlb_q <= wr_fl ? cfg_wdata[N_UTLB-1:0] : '0;
         if (go) begin
            if (done) begin
               act_q <= 1'b0;
            end else begin
               act_q <= 1'b1;
               cur_q <= sel_op;
               idx_q <= idx_now + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iaddr_q <= '0;
         imask_q <= '0;
         waddr_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_IADDR && !pend_q[OP_INVP]) iaddr_q <= cfg_wdata[VA_W-1:0];
         if (cfg_sel == SEL_IMASK && !pend_q[OP_INVP]) imask_q <= cfg_wdata[VA_W-1:0];
         if (cfg_sel == SEL_WADDR && !pend_q[OP_INVW]) waddr_q <= cfg_wdata[VA_W-1:0];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (cfg_sel)
         SEL_IADDR: cfg_rdata = REG_W'(iaddr_q);
         SEL_IMASK: cfg_rdata = REG_W'(imask_q);
         SEL_IGO:   cfg_rdata[0] = pend_q[OP_INVP];
         SEL_WADDR: cfg_rdata = REG_W'(waddr_q);
         SEL_WGO:   cfg_rdata[0] = pend_q[OP_INVW];
         SEL_FLUSH: begin
            cfg_rdata[FL_WALK_BIT]  = pend_q[OP_FLW];
            cfg_rdata[FL_PAGE_BIT]  = pend_q[OP_FLP];
            cfg_rdata[N_UTLB-1:0]   = utlb_q;
         end
         default:   cfg_rdata = '0;
      endcase
   end

   assign inv_addr  = iaddr_q;
   assign inv_mask  = imask_q;
   assign walk_addr = waddr_q;
   assign sc_page   = go && tgt_page;
   assign sc_walk   = go && !tgt_page;
   assign sc_all    = (sel_op == OP_FLW) || (sel_op == OP_FLP);
   assign sc_idx    = idx_now;
   assign pend_o    = pend_q;
   assign utlb_o    = utlb_q;
   assign busy_o    = (|pend_q) || (|utlb_q);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int FR_W   = 20,
   parameter int ACI_W  = 4,
   parameter int TBL_W  = 22,
   parameter int MAIN_N = 8,
   parameter int WALK_N = 4,
   parameter int N_UTLB = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [VA_W-1:0]   lk_va,
   output logic              lk_hit,
   output logic [FR_W-1:0]   lk_frame,
   output logic [ACI_W-1:0]  lk_aci,
   input  logic              fl_valid,
   input  logic [VA_W-1:0]   fl_va,
   input  logic [FR_W-1:0]   fl_frame,
   input  logic [ACI_W-1:0]  fl_aci,
   input  logic [VA_W-1:0]   wl_va,
   output logic              wl_hit,
   output logic [TBL_W-1:0]  wl_table,
   input  logic              wf_valid,
   input  logic [VA_W-1:0]   wf_va,
   input  logic [TBL_W-1:0]  wf_table,
   output logic [N_UTLB-1:0] utlb_flush
);
   localparam int PTAG_W = VA_W - PG_SHIFT;
   localparam int DTAG_W = VA_W - DIR_SHIFT;
   localparam int PDAT_W = FR_W + ACI_W;
   localparam int MAXN   = (MAIN_N > WALK_N) ? MAIN_N : WALK_N;
   localparam int CNT_W  = $clog2(MAXN);
   localparam int PIDX_W = $clog2(MAIN_N);
   localparam int WIDX_W = $clog2(WALK_N);

   if (VA_W > REG_W || VA_W <= DIR_SHIFT) begin : g_bad_va
      $error("xlat_cache: VA_W must lie in (DIR_SHIFT, REG_W]");
   end
   if (N_UTLB < 1 || N_UTLB > FL_PAGE_BIT) begin : g_bad_utlb
      $error("xlat_cache: N_UTLB must lie in [1, 16]");
   end
   if (MAIN_N < 2 || WALK_N < 2) begin : g_bad_n
      $error("xlat_cache: both arrays need at least two entries");
   end

   logic [VA_W-1:0]   inv_addr, inv_mask, walk_addr;
   logic              sc_page, sc_walk, sc_all, busy;
   logic [CNT_W-1:0]  sc_idx;
   logic [N_OPS-1:0]  pend;
   logic [MAIN_N-1:0] p_vld, p_hit;
   logic [WALK_N-1:0] w_vld, w_hit;
   logic [PDAT_W-1:0] p_dat;

   xlat_maint #(
      .VA_W(VA_W), .MAIN_N(MAIN_N), .WALK_N(WALK_N), .N_UTLB(N_UTLB), .CNT_W(CNT_W)
   ) u_mnt (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .inv_addr(inv_addr), .inv_mask(inv_mask), .walk_addr(walk_addr),
      .sc_page(sc_page), .sc_walk(sc_walk), .sc_all(sc_all), .sc_idx(sc_idx),
      .pend_o(pend), .utlb_o(utlb_flush), .busy_o(busy)
   );

   xlat_assoc #(.TAG_W(PTAG_W), .DAT_W(PDAT_W), .DEPTH(MAIN_N), .IDX_W(PIDX_W)) u_page (
      .clk(clk), .rst_n(rst_n),
      .lk_tag(lk_va[VA_W-1:PG_SHIFT]), .lk_hit(lk_hit), .lk_dat(p_dat),
      .fl_en(fl_valid && !busy), .fl_tag(fl_va[VA_W-1:PG_SHIFT]),
      .fl_dat({fl_frame, fl_aci}),
      .sc_en(sc_page), .sc_all(sc_all), .sc_idx(sc_idx[PIDX_W-1:0]),
      .sc_tag(inv_addr[VA_W-1:PG_SHIFT]), .sc_mask(inv_mask[VA_W-1:PG_SHIFT]),
      .vld_o(p_vld), .hit_o(p_hit)
   );

   xlat_assoc #(.TAG_W(DTAG_W), .DAT_W(TBL_W), .DEPTH(WALK_N), .IDX_W(WIDX_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .lk_tag(wl_va[VA_W-1:DIR_SHIFT]), .lk_hit(wl_hit), .lk_dat(wl_table),
      .fl_en(wf_valid && !busy), .fl_tag(wf_va[VA_W-1:DIR_SHIFT]), .fl_dat(wf_table),
      .sc_en(sc_walk), .sc_all(sc_all), .sc_idx(sc_idx[WIDX_W-1:0]),
      .sc_tag(walk_addr[VA_W-1:DIR_SHIFT]), .sc_mask({DTAG_W{1'b1}}),
      .vld_o(w_vld), .hit_o(w_hit)
   );

   assign lk_frame = p_dat[PDAT_W-1:ACI_W];
   assign lk_aci   = p_dat[ACI_W-1:0];

   logic unused_bits;
   assign unused_bits = ^{lk_va[PG_SHIFT-1:0], fl_va[PG_SHIFT-1:0],
                          wl_va[DIR_SHIFT-1:0], wf_va[DIR_SHIFT-1:0],
                          inv_addr[PG_SHIFT-1:0], inv_mask[PG_SHIFT-1:0],
                          walk_addr[DIR_SHIFT-1:0], sc_idx, w_hit};
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
   parameter int MAIN_N = 8,
   parameter int WALK_N = 4,
   parameter int N_UTLB = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [2:0]        cfg_sel,
   input logic              wbit0,
   input logic              fl_valid,
   input logic              wf_valid,
   input logic              busy,
   input logic [3:0]        pend,
   input logic [N_UTLB-1:0] utlb,
   input logic [MAIN_N-1:0] p_vld,
   input logic [MAIN_N-1:0] p_hit,
   input logic [WALK_N-1:0] w_vld
);
   AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_sel == 3'd2 && wbit0) |=> pend[2]);  // R5

   AST_PAGE_FILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && fl_valid) |=> ((p_vld & ~$past(p_vld)) == '0));  // R9

   AST_WALK_FILL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wf_valid) |=> ((w_vld & ~$past(w_vld)) == '0));  // R9

   AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(p_hit));  // R3

   AST_PAGE_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[1]) |-> (p_vld == '0));  // R7

   AST_WALK_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[0]) |-> (w_vld == '0));  // R7

   AST_UTLB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ((utlb != '0) && !(cfg_we && cfg_sel == 3'd5)) |=> (utlb == '0));  // R8
endmodule

bind xlat_cache xlat_cache_chk #(.MAIN_N(MAIN_N), .WALK_N(WALK_N), .N_UTLB(N_UTLB)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .wbit0(cfg_wdata[0]),
   .fl_valid(fl_valid), .wf_valid(wf_valid), .busy(busy), .pend(pend),
   .utlb(utlb_flush), .p_vld(p_vld), .p_hit(p_hit), .w_vld(w_vld)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   localparam int CLK_P = 10;
   localparam int WDOG  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] lk_va = '0;
   logic        lk_hit;
   logic [19:0] lk_frame;
   logic [3:0]  lk_aci;
   logic        fl_valid = 1'b0;
   logic [31:0] fl_va = '0;
   logic [19:0] fl_frame = '0;
   logic [3:0]  fl_aci = '0;
   logic [31:0] wl_va = '0;
   logic        wl_hit;
   logic [21:0] wl_table;
   logic        wf_valid = 1'b0;
   logic [31:0] wf_va = '0;
   logic [21:0] wf_table = '0;
   logic [5:0]  utlb_flush;

   int n_chk = 0;
   int n_bad = 0;

   xlat_cache u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .lk_va(lk_va), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_aci(lk_aci),
      .fl_valid(fl_valid), .fl_va(fl_va), .fl_frame(fl_frame), .fl_aci(fl_aci),
      .wl_va(wl_va), .wl_hit(wl_hit), .wl_table(wl_table),
      .wf_valid(wf_valid), .wf_va(wf_va), .wf_table(wf_table),
      .utlb_flush(utlb_flush)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [31:0] d);
      cfg_sel = sel;
      #1;
      d = cfg_rdata;
   endtask

   task automatic fill(input logic [31:0] va, input logic [19:0] fr, input logic [3:0] a);
      fl_valid = 1'b1; fl_va = va; fl_frame = fr; fl_aci = a;
      @(negedge clk);
      fl_valid = 1'b0;
   endtask

   task automatic wfill(input logic [31:0] va, input logic [21:0] t);
      wf_valid = 1'b1; wf_va = va; wf_table = t;
      @(negedge clk);
      wf_valid = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, output logic h, output logic [23:0] fa);
      lk_va = va;
      #1;
      h = lk_hit;
      fa = {lk_frame, lk_aci};
   endtask

   task automatic wlook(input logic [31:0] va, output logic h, output logic [21:0] t);
      wl_va = va;
      #1;
      h = wl_hit;
      t = wl_table;
   endtask

   task automatic wait_clear(input logic [2:0] sel, input int b);
      logic [31:0] d;
      for (int i = 0; i < 100; i++) begin
         rd(sel, d);
         if (!d[b]) return;
         @(negedge clk);
      end
   endtask

   function automatic logic [31:0] pg(input int i);
      return 32'h0004_0000 + (i << 12);
   endfunction

   // R1
   task automatic t_reset();
      logic [31:0] d;
      logic h;
      logic [23:0] fa;
      logic [21:0] t;
      do_reset();
      for (int s = 0; s < 6; s++) begin
         rd(3'(s), d);
         chk("R1 reg", d, 0);
      end
      look(pg(0), h, fa);
      chk("R1 page empty", h, 0);
      wlook(32'h0010_0000, h, t);
      chk("R1 walk empty", h, 0);
      chk("R1 utlb idle", utlb_flush, 0);
   endtask

   // R2, R3
   task automatic t_fill_lookup();
      logic h;
      logic [23:0] fa;
      do_reset();
      for (int i = 0; i < 9; i++) fill(pg(i), 20'hA0000 + 20'(i), 4'(i + 1));
      look(pg(2) | 32'hABC, h, fa);
      chk("R2 hit with offset", {h, fa}, {1'b1, 20'hA0002, 4'd3});
      look(pg(20), h, fa);
      chk("R2 miss uncached", h, 0);
      look(pg(0), h, fa);
      chk("R3 oldest evicted by ninth fill", h, 0);
      look(pg(8), h, fa);
      chk("R3 ninth fill present", {h, fa}, {1'b1, 20'hA0008, 4'd9});
      fill(pg(3), 20'h55555, 4'd7);
      look(pg(3), h, fa);
      chk("R3 refill in place", {h, fa}, {1'b1, 20'h55555, 4'd7});
      look(pg(1), h, fa);
      chk("R3 refill did not advance pointer", h, 1);
   endtask

   // R4, R5, R10
   task automatic t_mask_all_same_cycle();
      logic h;
      logic [23:0] fa;
      logic [31:0] d;
      do_reset();
      for (int i = 0; i < 8; i++) fill(pg(i), 20'hB0000 + 20'(i), 4'd2);
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h1);
      look(pg(0), h, fa);
      chk("R10 slot being removed misses", h, 0);
      look(pg(1), h, fa);
      chk("R10 later slot still hits", h, 1);
      for (int i = 0; i < 8; i++) begin
         rd(3'd2, d);
         chk("R5 busy while scanning", d[0], 1);
         @(negedge clk);
      end
      rd(3'd2, d);
      chk("R5 busy self-clears", d[0], 0);
      look(pg(7), h, fa);
      chk("R4 mask zero removes all", h, 0);
   endtask

   // R4
   task automatic t_mask_page();
      logic h;
      logic [23:0] fa;
      do_reset();
      for (int i = 4; i < 7; i++) fill(pg(i), 20'hC0000 + 20'(i), 4'd4);
      wr(3'd0, pg(5));
      wr(3'd1, 32'hFFFF_F000);
      wr(3'd2, 32'h1);
      wait_clear(3'd2, 0);
      look(pg(5), h, fa);
      chk("R4 single page removed", h, 0);
      look(pg(4), h, fa);
      chk("R4 lower neighbour kept", h, 1);
      look(pg(6), h, fa);
      chk("R4 upper neighbour kept", h, 1);
   endtask

   // R4, R11
   task automatic t_mask_broad_lock();
      logic h;
      logic [23:0] fa;
      logic [31:0] d;
      do_reset();
      fill(32'h1230_0000, 20'h00001, 4'd1);
      fill(32'h1234_5000, 20'h00002, 4'd1);
      fill(32'h124A_B000, 20'h00003, 4'd1);
      wr(3'd0, 32'h1230_0000);
      wr(3'd1, 32'hFFF0_0FFF);
      wr(3'd2, 32'h1);
      wr(3'd0, 32'hDEAD_0000);
      wr(3'd1, 32'h0);
      wait_clear(3'd2, 0);
      rd(3'd0, d);
      chk("R11 address write ignored while busy", d, 32'h1230_0000);
      rd(3'd1, d);
      chk("R11 mask write ignored while busy", d, 32'hFFF0_0FFF);
      look(32'h1234_5000, h, fa);
      chk("R4 region mask removes page", h, 0);
      look(32'h124A_B000, h, fa);
      chk("R4 region mask keeps outside page", h, 1);
      wr(3'd0, 32'h5555_5000);
      rd(3'd0, d);
      chk("R11 address write accepted when idle", d, 32'h5555_5000);
   endtask

   // R6, R7
   task automatic t_walk_and_flush();
      logic h;
      logic [23:0] fa;
      logic [21:0] t;
      logic [31:0] d;
      do_reset();
      wfill(32'h0010_0000, 22'h11111);
      wfill(32'h0020_0000, 22'h22222);
      fill(pg(1), 20'hD0001, 4'd5);
      wr(3'd3, 32'h0015_4000);
      wr(3'd4, 32'h1);
      for (int i = 0; i < 5; i++) begin
         rd(3'd4, d);
         chk("R6 walk busy window", d[0], (i < 4) ? 1 : 0);
         @(negedge clk);
      end
      wlook(32'h001F_FFFF, h, t);
      chk("R6 covering region removed", h, 0);
      wlook(32'h0020_1234, h, t);
      chk("R6 other region kept", {h, t}, {1'b1, 22'h22222});
      wr(3'd5, 32'h0002_0000);
      rd(3'd5, d);
      chk("R7 walk flush busy", d[17], 1);
      wait_clear(3'd5, 17);
      wlook(32'h0020_0000, h, t);
      chk("R7 walk flush empties walk", h, 0);
      look(pg(1), h, fa);
      chk("R7 walk flush keeps pages", h, 1);
      wfill(32'h0030_0000, 22'h33333);
      wr(3'd5, 32'h0001_0000);
      rd(3'd5, d);
      chk("R7 page flush busy", d[16], 1);
      wait_clear(3'd5, 16);
      look(pg(1), h, fa);
      chk("R7 page flush empties pages", h, 0);
      wlook(32'h0030_0000, h, t);
      chk("R7 page flush keeps walk", h, 1);
   endtask

   // R12
   task automatic t_queue();
      logic [31:0] d;
      do_reset();
      wr(3'd5, 32'h0003_0000);
      for (int i = 0; i < 13; i++) begin
         rd(3'd5, d);
         chk("R12 walk flush first", d[17], (i < 4) ? 1 : 0);
         chk("R12 page flush waits then runs", d[16], (i < 12) ? 1 : 0);
         @(negedge clk);
      end
   endtask

   // R8
   task automatic t_utlb();
      logic [31:0] d;
      do_reset();
      wr(3'd5, 32'h0000_002A);
      chk("R8 strobe out", utlb_flush, 6'h2A);
      rd(3'd5, d);
      chk("R8 strobe readback", d, 32'h2A);
      @(negedge clk);
      chk("R8 strobe one cycle", utlb_flush, 0);
      rd(3'd5, d);
      chk("R8 readback clears", d, 0);
   endtask

   // R9
   task automatic t_fill_drop();
      logic h;
      logic [23:0] fa;
      logic [21:0] t;
      do_reset();
      wr(3'd3, 32'hFF00_0000);
      wr(3'd4, 32'h1);
      fill(pg(30), 20'hE0000, 4'd1);
      wfill(32'h0050_0000, 22'h0ABCD);
      wait_clear(3'd4, 0);
      look(pg(30), h, fa);
      chk("R9 page fill dropped while busy", h, 0);
      wlook(32'h0050_0000, h, t);
      chk("R9 walk fill dropped while busy", h, 0);
      wr(3'd5, 32'h1);
      fill(pg(31), 20'hE0001, 4'd1);
      look(pg(31), h, fa);
      chk("R9 fill dropped during strobe", h, 0);
      fill(pg(31), 20'hE0001, 4'd1);
      look(pg(31), h, fa);
      chk("R9 fill accepted when idle", h, 1);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fill_lookup();
      t_mask_all_same_cycle();
      t_mask_page();
      t_mask_broad_lock();
      t_walk_and_flush();
      t_queue();
      t_utlb();
      t_fill_drop();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule